// File: doc/BRIEF.md
# Single Conversion Acquisition Sequencer

This block drives a serial delta-sigma converter through one complete single-shot measurement. On a start pulse it opens a frame, reads the converter's 24-bit configuration word, forces the port-flag bit (bit 5) to one while leaving every other bit as it was, and writes the word back in a second frame. A third frame then carries the single-conversion command. Inside that frame the converter's data-out line acts as a ready flag. The sequencer keeps the serial clock parked low and watches the line until the converter pulls it low. It then sends eight clocks with data-in held low to clear the flag, and clocks in the 24-bit result most significant bit first.

The captured word is presented raw and also split according to a format select. The 20-bit form and the 16-bit form each yield the data bits, an overflow flag and an oscillation-detect flag. A one-cycle completion strobe follows once chip select has been released. A programmable cycle limit bounds the wait for the ready flag. If the limit is reached first, the frame is closed and a one-cycle error strobe is raised in place of the completion strobe.

States, in order of travel: `ST_IDLE` → (start) `ST_CFG_READ` → (32 bits shifted) `ST_CFG_GAP` → `ST_CFG_WRITE` → (32 bits shifted) `ST_WR_GAP` → `ST_CONV_CMD` → (8 bits shifted) `ST_WAIT_RDY` → (ready low) `ST_FLAG_CLR` → (8 bits shifted) `ST_RES_READ` → (24 bits shifted) `ST_FINISH` → `ST_IDLE`. From `ST_WAIT_RDY`, reaching the limit with the line still high leads to `ST_ABORT` → `ST_IDLE`. The gap states each last one cycle with chip select high.

Top module: `sconv_acq_seq`

## Requirements
- R1: The configuration word is read in a frame that starts with command byte 0x94. It is written back in a separate frame that starts with command byte 0x84 and carries the same word with bit 5 set to one and all other bits unchanged. A word that already has bit 5 set is written back unchanged.
- R2: After the write-back, a new frame carries the single-conversion command byte 0xC0. Exactly one such command is sent per start.
- R3: While waiting for the ready flag, `ser_clk` stays low. The wait ends as soon as the synchronised `ser_din` is seen low.
- R4: After the ready flag falls, exactly eight clocks are sent with `ser_dout` low. Then 24 clocks read the result, most significant bit first, into `res_raw`.
- R5: `ser_sel_n` stays low without a break from the conversion command through the last result bit.
- R6: With `fmt_20b` = 1, `res_data` = `res_raw[23:4]`, `res_osc` = `res_raw[1]` and `res_ovf` = `res_raw[0]`.
- R7: With `fmt_20b` = 0, `res_data` = {4'b0, `res_raw[23:8]`}, `res_osc` = `res_raw[1]` and `res_ovf` = `res_raw[0]`.
- R8: `done` is high for exactly one cycle per completed acquisition. In that cycle `ser_sel_n` is already high and the result outputs hold the new values.
- R9: If `ser_din` is still high after `wait_limit` cycles in the wait, `tmo_err` pulses for one cycle and `ser_sel_n` goes high. `done` does not pulse and the previous result outputs are kept.
- R10: If the ready flag is seen low in the same cycle that the wait limit is reached, the acquisition proceeds and completes normally.
- R11: A start pulse while `busy` is high has no effect.
- R12: After reset, `ser_sel_n` = 1, `ser_clk` = 0, and `done`, `tmo_err` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run one acquisition |
| fmt_20b | input | 1 | 1 = 20-bit result format, 0 = 16-bit; sampled at start |
| wait_limit | input | TMO_W | Cycle limit for the ready wait |
| ser_clk | output | 1 | Serial bit clock to the converter, idle low |
| ser_sel_n | output | 1 | Active-low converter select |
| ser_dout | output | 1 | Serial data toward the converter |
| ser_din | input | 1 | Serial data / ready flag from the converter |
| res_raw | output | 24 | Last captured result word |
| res_data | output | 20 | Decoded data bits, right-aligned |
| res_ovf | output | 1 | Decoded overflow flag |
| res_osc | output | 1 | Decoded oscillation-detect flag |
| done | output | 1 | One-cycle completion strobe |
| tmo_err | output | 1 | One-cycle ready-wait timeout strobe |
| busy | output | 1 | High while a sequence is in progress |

## Verification
The ready-flag detection and the wait-limit expiry can both be true in the same cycle of `ST_WAIT_RDY`. The bench provokes this by setting `wait_limit` to zero and having the converter model drop its data-out line at the moment it decodes the conversion command. The line is then already low, through the synchronizer, when the state is first entered, so both conditions hold in that first wait cycle. The case is judged at the ports: a `done` pulse, no `tmo_err`, and a correctly decoded result show that readiness took priority.

// File: rtl/sconv_pkg.sv
package sconv_pkg;

    localparam int WORD_W  = 24;
    localparam int FRAME_W = 32;
    localparam int CNT_W   = 6;
    localparam int PF_BIT  = 5;

    localparam logic [7:0] CMD_CFG_RD = 8'h94;
    localparam logic [7:0] CMD_CFG_WR = 8'h84;
    localparam logic [7:0] CMD_SINGLE = 8'hC0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CFG_READ,
        ST_CFG_GAP,
        ST_CFG_WRITE,
        ST_WR_GAP,
        ST_CONV_CMD,
        ST_WAIT_RDY,
        ST_FLAG_CLR,
        ST_RES_READ,
        ST_FINISH,
        ST_ABORT
    } acq_state_e;

    function automatic logic is_shift_state(acq_state_e s);
        return (s == ST_CFG_READ) || (s == ST_CFG_WRITE) || (s == ST_CONV_CMD) ||
               (s == ST_FLAG_CLR) || (s == ST_RES_READ);
    endfunction

    function automatic logic is_select_state(acq_state_e s);
        return is_shift_state(s) || (s == ST_WAIT_RDY);
    endfunction

endpackage

// File: rtl/sconv_bit_engine.sv
module sconv_bit_engine #(
    parameter int HALF        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go,
    input  logic [sconv_pkg::CNT_W-1:0]  nbits,
    input  logic [sconv_pkg::FRAME_W-1:0] tx_word,
    input  logic                         din,
    output logic                         din_s,
    output logic                         sclk,
    output logic                         dout,
    output logic                         busy,
    output logic                         fin,
    output logic [sconv_pkg::WORD_W-1:0] rx_word
);
    import sconv_pkg::*;

    localparam int HCNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HCNT_W-1:0] HCNT_LAST = HCNT_W'(HALF - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HCNT_W-1:0]      hcnt_q;
    logic [CNT_W-1:0]       bcnt_q;
    logic [FRAME_W-1:0]     tx_q;
    logic [WORD_W-1:0]      rx_q;
    logic                   sclk_q;
    logic                   dout_q;
    logic                   busy_q;
    logic                   half_end;

    generate
        if (SYNC_STAGES > 1) begin : g_sync_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            end
        end else begin : g_sync_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= din;
            end
        end
    endgenerate

    assign din_s    = sync_q[SYNC_STAGES-1];
    assign half_end = (hcnt_q == HCNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            dout_q <= 1'b0;
            hcnt_q <= '0;
            bcnt_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            hcnt_q <= '0;
            bcnt_q <= nbits - CNT_W'(1);
            tx_q   <= tx_word;
            dout_q <= tx_word[FRAME_W-1];
        end else if (busy_q) begin
            if (half_end) begin
                hcnt_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[WORD_W-2:0], din_s};
                end else begin
                    sclk_q <= 1'b0;
                    if (bcnt_q == '0) begin
                        busy_q <= 1'b0;
                        dout_q <= 1'b0;
                    end else begin
                        bcnt_q <= bcnt_q - CNT_W'(1);
                        tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
                        dout_q <= tx_q[FRAME_W-2];
                    end
                end
            end else begin
                hcnt_q <= hcnt_q + HCNT_W'(1);
            end
        end
    end

    assign fin     = busy_q && sclk_q && half_end && (bcnt_q == '0);
    assign sclk    = sclk_q;
    assign dout    = dout_q;
    assign busy    = busy_q;
    assign rx_word = rx_q;

endmodule

// File: rtl/sconv_wait_timer.sv
module sconv_wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + TMO_W'(1);
        else          cnt_q <= '0;
    end

    assign expired = run && (cnt_q == limit);

endmodule

// File: rtl/sconv_result_unpack.sv
module sconv_result_unpack (
    input  logic [sconv_pkg::WORD_W-1:0] raw,
    input  logic                         fmt_20b,
    output logic [19:0]                  data,
    output logic                         ovf,
    output logic                         osc
);
    always_comb begin
        if (fmt_20b) data = raw[23:4];
        else         data = {4'b0000, raw[23:8]};
        osc = raw[1];
        ovf = raw[0];
    end
endmodule

// File: rtl/sconv_acq_seq.sv
module sconv_acq_seq #(
    parameter int SCLK_HALF   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TMO_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fmt_20b,
    input  logic [TMO_W-1:0] wait_limit,
    output logic             ser_clk,
    output logic             ser_sel_n,
    output logic             ser_dout,
    input  logic             ser_din,
    output logic [23:0]      res_raw,
    output logic [19:0]      res_data,
    output logic             res_ovf,
    output logic             res_osc,
    output logic             done,
    output logic             tmo_err,
    output logic             busy
);
    import sconv_pkg::*;

    localparam logic [WORD_W-1:0] PF_MASK = WORD_W'(1) << PF_BIT;

    acq_state_e state, nxt;

    logic               eng_go, eng_busy, eng_fin, din_s, wait_expired;
    logic [CNT_W-1:0]   eng_nbits;
    logic [FRAME_W-1:0] eng_tx;
    logic [WORD_W-1:0]  eng_rx;
    logic [WORD_W-1:0]  cfg_q, raw_q;
    logic               fmt_q, res_fmt_q;
    logic               sel_n_q, done_q, err_q, busy_q;

    sconv_bit_engine #(
        .HALF        (SCLK_HALF),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (eng_go),
        .nbits   (eng_nbits),
        .tx_word (eng_tx),
        .din     (ser_din),
        .din_s   (din_s),
        .sclk    (ser_clk),
        .dout    (ser_dout),
        .busy    (eng_busy),
        .fin     (eng_fin),
        .rx_word (eng_rx)
    );

    sconv_wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_WAIT_RDY),
        .limit   (wait_limit),
        .expired (wait_expired)
    );

    sconv_result_unpack u_unpack (
        .raw     (raw_q),
        .fmt_20b (res_fmt_q),
        .data    (res_data),
        .ovf     (res_ovf),
        .osc     (res_osc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = ST_CFG_READ;
            ST_CFG_READ:  if (eng_fin) nxt = ST_CFG_GAP;
            ST_CFG_GAP:   nxt = ST_CFG_WRITE;
            ST_CFG_WRITE: if (eng_fin) nxt = ST_WR_GAP;
            ST_WR_GAP:    nxt = ST_CONV_CMD;
            ST_CONV_CMD:  if (eng_fin) nxt = ST_WAIT_RDY;
            ST_WAIT_RDY: begin
                if (!din_s)            nxt = ST_FLAG_CLR;
                else if (wait_expired) nxt = ST_ABORT;
            end
            ST_FLAG_CLR:  if (eng_fin) nxt = ST_RES_READ;
            ST_RES_READ:  if (eng_fin) nxt = ST_FINISH;
            ST_FINISH:    nxt = ST_IDLE;
            ST_ABORT:     nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // shift request toward the bit engine
    always_comb begin
        eng_go    = (nxt != state) && is_shift_state(nxt);
        eng_nbits = CNT_W'(8);
        eng_tx    = '0;
        unique case (nxt)
            ST_CFG_READ: begin
                eng_nbits = CNT_W'(FRAME_W);
                eng_tx    = {CMD_CFG_RD, {WORD_W{1'b0}}};
            end
            ST_CFG_WRITE: begin
                eng_nbits = CNT_W'(FRAME_W);
                eng_tx    = {CMD_CFG_WR, cfg_q};
            end
            ST_CONV_CMD: begin
                eng_tx    = {CMD_SINGLE, {WORD_W{1'b0}}};
            end
            ST_RES_READ: begin
                eng_nbits = CNT_W'(WORD_W);
            end
            default: begin
                eng_nbits = CNT_W'(8);
            end
        endcase
    end

    // data captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            raw_q     <= '0;
            fmt_q     <= 1'b1;
            res_fmt_q <= 1'b1;
        end else begin
            if (state == ST_IDLE && start)
                fmt_q <= fmt_20b;
            if (state == ST_CFG_READ && eng_fin)
                cfg_q <= eng_rx | PF_MASK;
            if (state == ST_RES_READ && eng_fin) begin
                raw_q     <= eng_rx;
                res_fmt_q <= fmt_q;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_n_q <= 1'b1;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            sel_n_q <= !is_select_state(nxt);
            done_q  <= (nxt == ST_FINISH);
            err_q   <= (nxt == ST_ABORT);
            busy_q  <= (nxt != ST_IDLE);
        end
    end

    assign ser_sel_n = sel_n_q;
    assign done      = done_q;
    assign tmo_err   = err_q;
    assign busy      = busy_q;
    assign res_raw   = raw_q;

    // R1: the word going back out has the port flag forced
    p_cfg_pf_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CFG_WRITE) |-> cfg_q[PF_BIT]);

    // R3: no bit clock while waiting for the ready flag
    p_wait_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RDY) |-> !ser_clk);

    // R4: data toward the converter held low while clearing the flag
    p_clear_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLAG_CLR) |-> !ser_dout);

    // R5: select held from the wait through the result read
    p_sel_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAIT_RDY) || (state == ST_FLAG_CLR) || (state == ST_RES_READ))
        |-> !ser_sel_n);

    // R8: completion strobe lasts one cycle, select already released
    p_done_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ser_sel_n && !eng_busy));

    // R9: error strobe never accompanies completion
    p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> (!done && ser_sel_n));

endmodule

// File: tb/sconv_acq_seq_tb.sv
module sconv_acq_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fmt_20b = 1'b1;
    logic [15:0] wait_limit = 16'd1000;
    logic        ser_clk, ser_sel_n, ser_dout, ser_din;
    logic [23:0] res_raw;
    logic [19:0] res_data;
    logic        res_ovf, res_osc, done, tmo_err, busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    sconv_acq_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fmt_20b    (fmt_20b),
        .wait_limit (wait_limit),
        .ser_clk    (ser_clk),
        .ser_sel_n  (ser_sel_n),
        .ser_dout   (ser_dout),
        .ser_din    (ser_din),
        .res_raw    (res_raw),
        .res_data   (res_data),
        .res_ovf    (res_ovf),
        .res_osc    (res_osc),
        .done       (done),
        .tmo_err    (tmo_err),
        .busy       (busy)
    );

    // ---------------- converter model ----------------
    logic [23:0] m_cfg = 24'h0;
    logic [23:0] m_result = 24'h0;
    logic [23:0] m_out = 24'h0;
    logic [23:0] m_wr = 24'h0;
    logic [7:0]  m_cmd = 8'h0;
    logic        m_miso = 1'b1;
    logic        sclk_prev = 1'b0;
    logic        sel_prev = 1'b1;
    int  m_delay = 20;
    bit  m_never = 1'b0;
    int  m_phase = 6;
    int  m_cnt = 0;
    int  conv_cnt = 0;
    int  n_cfg_rd = 0, n_cfg_wr = 0, n_conv = 0;
    int  n_wait_clk = 0, n_clr_bad = 0, n_cs_break = 0;

    assign ser_din = m_miso;

    always @(posedge clk) begin
        if (rst_n) begin
            if (sel_prev && !ser_sel_n) begin
                m_phase = 0;
                m_cnt   = 0;
                m_cmd   = 8'h0;
                m_miso <= 1'b1;
            end
            if (!sel_prev && ser_sel_n) begin
                if (m_phase >= 3 && m_phase <= 5) n_cs_break++;
                m_phase = 6;
            end
            if (!ser_sel_n && ser_clk && !sclk_prev) begin
                case (m_phase)
                    0: begin
                        m_cmd = {m_cmd[6:0], ser_dout};
                        m_cnt++;
                        if (m_cnt == 8) begin
                            m_cnt = 0;
                            if (m_cmd == 8'h94) begin
                                n_cfg_rd++;
                                m_phase = 1;
                                m_out   = m_cfg;
                                m_miso <= m_cfg[23];
                            end else if (m_cmd == 8'h84) begin
                                m_phase = 2;
                                m_wr    = 24'h0;
                            end else if (m_cmd == 8'hC0) begin
                                n_conv++;
                                conv_cnt = 0;
                                if (!m_never && m_delay == 0) begin
                                    m_miso <= 1'b0;
                                    m_phase = 4;
                                end else begin
                                    m_phase = 3;
                                end
                            end else begin
                                m_phase = 6;
                            end
                        end
                    end
                    1, 5: begin
                        m_out = {m_out[22:0], 1'b0};
                        m_miso <= m_out[23];
                        m_cnt++;
                        if (m_cnt == 24) m_phase = 6;
                    end
                    2: begin
                        m_wr = {m_wr[22:0], ser_dout};
                        m_cnt++;
                        if (m_cnt == 24) begin
                            m_cfg = m_wr;
                            n_cfg_wr++;
                            m_phase = 6;
                        end
                    end
                    3: n_wait_clk++;
                    4: begin
                        if (ser_dout) n_clr_bad++;
                        m_cnt++;
                        if (m_cnt == 8) begin
                            m_cnt   = 0;
                            m_phase = 5;
                            m_out   = m_result;
                            m_miso <= m_result[23];
                        end
                    end
                    default: ;
                endcase
            end
            if (m_phase == 3) begin
                conv_cnt++;
                if (!m_never && conv_cnt >= m_delay) begin
                    m_miso <= 1'b0;
                    m_phase = 4;
                    m_cnt   = 0;
                end
            end
            sclk_prev = ser_clk;
            sel_prev  = ser_sel_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_model_counts();
        n_cfg_rd = 0; n_cfg_wr = 0; n_conv = 0;
        n_wait_clk = 0; n_clr_bad = 0; n_cs_break = 0;
    endtask

    task automatic pulse_start(input logic fmt);
        @(negedge clk);
        fmt_20b = fmt;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_err,
                            output bit sel_hi, output int width);
        got_done = 1'b0; got_err = 1'b0; sel_hi = 1'b0; width = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin
                got_done = 1'b1;
                sel_hi   = ser_sel_n;
                @(negedge clk);
                width = done ? 2 : 1;
                break;
            end
            if (tmo_err) begin
                got_err = 1'b1;
                sel_hi  = ser_sel_n;
                break;
            end
        end
        repeat (4) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk("R12 sel_n", 32'(ser_sel_n), 32'd1);
        chk("R12 ser_clk", 32'(ser_clk), 32'd0);
        chk("R12 done", 32'(done), 32'd0);
        chk("R12 tmo_err", 32'(tmo_err), 32'd0);
        chk("R12 busy", 32'(busy), 32'd0);
    endtask

    task automatic t_conv20();
        bit d, e, s; int w;
        clear_model_counts();
        m_cfg = 24'h000000; m_result = 24'hABCDE3; m_delay = 30; m_never = 0;
        wait_limit = 16'd1000;
        pulse_start(1'b1);
        wait_end(d, e, s, w);
        chk("R1 cfg written", 32'(m_cfg), 32'h000020);
        chk("R1 reads", 32'(n_cfg_rd), 32'd1);
        chk("R1 writes", 32'(n_cfg_wr), 32'd1);
        chk("R2 conv cmds", 32'(n_conv), 32'd1);
        chk("R3 clocks in wait", 32'(n_wait_clk), 32'd0);
        chk("R4 clear dout", 32'(n_clr_bad), 32'd0);
        chk("R4 raw", 32'(res_raw), 32'hABCDE3);
        chk("R5 sel breaks", 32'(n_cs_break), 32'd0);
        chk("R6 data", 32'(res_data), 32'hABCDE);
        chk("R6 osc", 32'(res_osc), 32'd1);
        chk("R6 ovf", 32'(res_ovf), 32'd1);
        chk("R8 done seen", 32'(d), 32'd1);
        chk("R8 done width", 32'(w), 32'd1);
        chk("R8 sel high at done", 32'(s), 32'd1);
        chk("R9 no error", 32'(e), 32'd0);
    endtask

    task automatic t_conv16();
        bit d, e, s; int w;
        clear_model_counts();
        m_cfg = 24'h5A5A0F; m_result = 24'h1234F2; m_delay = 45; m_never = 0;
        wait_limit = 16'd1000;
        pulse_start(1'b0);
        wait_end(d, e, s, w);
        chk("R1 cfg merge", 32'(m_cfg), 32'h5A5A2F);
        chk("R4 raw16", 32'(res_raw), 32'h1234F2);
        chk("R7 data", 32'(res_data), 32'h01234);
        chk("R7 osc", 32'(res_osc), 32'd1);
        chk("R7 ovf", 32'(res_ovf), 32'd0);
        chk("R8 done16", 32'(d), 32'd1);
    endtask

    task automatic t_pf_already();
        bit d, e, s; int w;
        clear_model_counts();
        m_cfg = 24'hFFFFFF; m_result = 24'h000001; m_delay = 10; m_never = 0;
        pulse_start(1'b1);
        wait_end(d, e, s, w);
        chk("R1 cfg unchanged", 32'(m_cfg), 32'hFFFFFF);
        chk("R6 data zero", 32'(res_data), 32'h0);
        chk("R6 ovf only", 32'({res_osc, res_ovf}), 32'd1);
    endtask

    task automatic t_timeout();
        bit d, e, s; int w;
        clear_model_counts();
        m_cfg = 24'h000000; m_result = 24'h777777; m_never = 1;
        wait_limit = 16'd60;
        pulse_start(1'b1);
        wait_end(d, e, s, w);
        chk("R9 error seen", 32'(e), 32'd1);
        chk("R9 no done", 32'(d), 32'd0);
        chk("R9 sel released", 32'(s), 32'd1);
        chk("R9 result kept", 32'(res_raw), 32'h000001);
        chk("R9 error one cycle", 32'(tmo_err), 32'd0);
        chk("R3 clocks during wait", 32'(n_wait_clk), 32'd0);
        m_never = 0;
    endtask

    task automatic t_coincide();
        bit d, e, s; int w;
        clear_model_counts();
        m_cfg = 24'h000000; m_result = 24'h3C3C30; m_delay = 0; m_never = 0;
        wait_limit = 16'd0;
        pulse_start(1'b1);
        wait_end(d, e, s, w);
        chk("R10 done wins", 32'(d), 32'd1);
        chk("R10 no error", 32'(e), 32'd0);
        chk("R10 raw", 32'(res_raw), 32'h3C3C30);
        wait_limit = 16'd1000;
    endtask

    task automatic t_busy_ignore();
        bit d, e, s; int w;
        clear_model_counts();
        m_cfg = 24'h000000; m_result = 24'h0F0F0F; m_delay = 25; m_never = 0;
        pulse_start(1'b1);
        repeat (150) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end(d, e, s, w);
        repeat (100) @(negedge clk);
        chk("R11 one config read", 32'(n_cfg_rd), 32'd1);
        chk("R11 one conversion", 32'(n_conv), 32'd1);
        chk("R11 idle after", 32'(busy), 32'd0);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_conv20();
        t_conv16();
        t_pf_already();
        t_timeout();
        t_coincide();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule